// File: doc/BRIEF.md
# Vector Issue Delay-Hint Stall Tracker

This block sits at the issue stage of a vector core. Software can place a delay-hint instruction ahead of a vector instruction to say that the consumer must wait for an earlier vector instruction. The hint names that instruction by its position, counted backwards in vector issue order. It does not name a register. The block records the last few vector instructions as a tag and a completion flag each. It takes completion pulses from the execution pipeline. It raises a stall on the next vector issue until the named instruction has completed.

The 16-bit hint immediate holds two dependency fields. The first dependency guards the next vector instruction. The second dependency guards a vector instruction placed a set number of vector issues later. A field whose count is zero, above four, or larger than the number of vector instructions issued since reset adds no stall. While the stall is high, the issue strobe is not accepted, so upstream logic holds the instruction and presents it again.

Top module: `alu_hint_stall`

## Requirements
- R1: After reset the history is empty, no hint is pending, the issued-vector count is zero and `stall_o` is low.
- R2: A hint whose first code `imm[3:0]` = N (1 to 4) makes `stall_o` high before the next vector issue while the vector instruction N back in issue order has not completed. `stall_o` falls in the cycle after the edge that registers that instruction's completion.
- R3: A code of 0, or a code of 5 to 15, in either dependency field produces no stall.
- R4: A code N larger than the number of vector instructions issued since reset produces no stall. The count saturates at the history depth of 4.
- R5: The target is the instruction N positions back, whatever its tag. A completed instruction at that position releases the stall even when an older instruction is still in flight.
- R6: While `stall_o` is high, an asserted `issue_valid_i` is not accepted. It changes neither the history nor the pending hint.
- R7: A pending hint is consumed by the first accepted vector issue. Later vector issues see no stall from the first field.
- R8: The second code `imm[10:7]` guards the vector instruction that lies `imm[6:4]` vector issues after the first guarded one, where 0 means that same instruction. Its target is counted back from the history present when the guarded instruction is about to issue. The vector issues before it are not stalled by this field.
- R9: A hint issue (`issue_hint_i`=1) does not enter the history and does not advance the vector count.
- R10: A completion pulse marks every history entry whose tag equals `cmpl_tag_i`. A pulse with a tag that matches no entry has no effect. Completion marks are sticky until the entry shifts out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Instruction presented for issue |
| issue_hint_i | input | 1 | 1 = delay hint, 0 = vector instruction |
| issue_imm_i | input | 16 | Hint immediate |
| issue_tag_i | input | TAG_W (4) | Tag of the vector instruction being issued |
| cmpl_valid_i | input | 1 | Completion pulse from the pipeline |
| cmpl_tag_i | input | TAG_W (4) | Tag of the completed instruction |
| stall_o | output | 1 | Holds the presented issue |

## Verification
The first field is swept over every code value, for every issued-vector count from zero to five, and for every pattern of completed entries. This separates a correct target position from an off-by-one position, out-of-range codes from legal ones, and counts that have run past the history from counts that have not. The second field is swept over skip values and codes, with younger vector instructions issued in between. This shows whether the guarded instruction is the right one and whether its target is counted from the updated history. Directed sequences cover a held issue during a stall, both fields on the same instruction, a completion with a foreign tag, and hints that do not advance the count.

// File: rtl/alu_hint_pkg.sv
package alu_hint_pkg;
  localparam int IMM_W  = 16;
  localparam int CODE_W = 4;
  localparam int SKIP_W = 3;

  typedef struct packed {
    logic [CODE_W-1:0] code_b;
    logic [SKIP_W-1:0] skip;
    logic [CODE_W-1:0] code_a;
  } hint_t;

  function automatic hint_t hint_decode(input logic [IMM_W-1:0] imm);
    hint_t h;
    h.code_a = imm[3:0];
    h.skip   = imm[6:4];
    h.code_b = imm[10:7];
    return h;
  endfunction
endpackage

// File: rtl/alu_hint_history.sv
module alu_hint_history #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [TAG_W-1:0] push_tag_i,
  input  logic             cmpl_i,
  input  logic [TAG_W-1:0] cmpl_tag_i,
  output logic [DEPTH-1:0] done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [DEPTH-1:0] done_q, done_d;
  logic [CNT_W-1:0] cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign done_d[i] = done_q[i] |
                       (cmpl_i && (tag_q[i] == cmpl_tag_i) && (CNT_W'(i) < cnt_q));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[i]  <= '0;
        done_q[i] <= 1'b0;
      end else if (push_i) begin
        if (i == 0) begin
          tag_q[i]  <= push_tag_i;
          done_q[i] <= 1'b0;
        end else begin
          tag_q[i]  <= tag_q[i-1];
          done_q[i] <= done_d[i-1];
        end
      end else begin
        done_q[i] <= done_d[i];
      end
    end

    AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!push_i && done_q[i]) |=> done_q[i]); // R10
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (push_i && cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = done_q;
  assign cnt_o  = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R4
  AST_PUSH_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> !done_q[0]); // R10
endmodule

// File: rtl/alu_hint_pending.sv
module alu_hint_pending
  import alu_hint_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hint_i,
  input  logic [IMM_W-1:0] hint_imm_i,
  input  logic             vec_i,
  input  logic [DEPTH-1:0] done_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             stall_o
);
  hint_t             dec;
  logic [CODE_W-1:0] code_a_q, code_b_q;
  logic [SKIP_W-1:0] skip_q;
  logic              wait_a, wait_b;

  assign dec = hint_decode(hint_imm_i);

  // Target counted back from the current history; out-of-range codes never match.
  function automatic logic blocked(input logic [CODE_W-1:0] code,
                                   input logic [DEPTH-1:0]  done,
                                   input logic [CNT_W-1:0]  cnt);
    logic b;
    b = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (code == CODE_W'(i + 1) && CNT_W'(i) < cnt && !done[i]) b = 1'b1;
    return b;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_a_q <= '0;
      code_b_q <= '0;
      skip_q   <= '0;
    end else if (hint_i) begin
      code_a_q <= dec.code_a;
      code_b_q <= dec.code_b;
      skip_q   <= dec.skip;
    end else if (vec_i) begin
      code_a_q <= '0;
      if (skip_q == '0) code_b_q <= '0;
      else              skip_q   <= skip_q - 1'b1;
    end
  end

  assign wait_a  = blocked(code_a_q, done_i, cnt_i);
  assign wait_b  = (skip_q == '0) && blocked(code_b_q, done_i, cnt_i);
  assign stall_o = wait_a | wait_b;

  AST_CONSUME_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_i |=> (code_a_q == '0)); // R7
  AST_STALL_NEEDS_HINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (code_a_q != '0 || code_b_q != '0)); // R3
  AST_EMPTY_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> !stall_o); // R4
endmodule

// File: rtl/alu_hint_stall.sv
module alu_hint_stall
  import alu_hint_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TAG_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_valid_i,
  input  logic             issue_hint_i,
  input  logic [15:0]      issue_imm_i,
  input  logic [TAG_W-1:0] issue_tag_i,
  input  logic             cmpl_valid_i,
  input  logic [TAG_W-1:0] cmpl_tag_i,
  output logic             stall_o
);
  logic             accept, push, hint;
  logic [DEPTH-1:0] done;
  logic [CNT_W-1:0] cnt;

  assign accept = issue_valid_i && !stall_o;
  assign push   = accept && !issue_hint_i;
  assign hint   = accept && issue_hint_i;

  alu_hint_history #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_tag_i (issue_tag_i),
    .cmpl_i     (cmpl_valid_i),
    .cmpl_tag_i (cmpl_tag_i),
    .done_o     (done),
    .cnt_o      (cnt)
  );

  alu_hint_pending #(.DEPTH(DEPTH)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hint_i     (hint),
    .hint_imm_i (issue_imm_i),
    .vec_i      (push),
    .done_i     (done),
    .cnt_i      (cnt),
    .stall_o    (stall_o)
  );

  AST_HOLD_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && issue_valid_i) |=> $stable(cnt)); // R6
  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && issue_valid_i && !cmpl_valid_i) |=> stall_o); // R6
  AST_HINT_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_hint_i) |=> $stable(cnt)); // R9
endmodule

// File: tb/sim_alu_hint_stall.sv
module sim_alu_hint_stall;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       issue_valid_i = 1'b0, issue_hint_i = 1'b0;
  logic [15:0] issue_imm_i = '0;
  logic [3:0] issue_tag_i = '0;
  logic       cmpl_valid_i = 1'b0;
  logic [3:0] cmpl_tag_i = '0;
  logic       stall_o;
  int         n_chk = 0, n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  alu_hint_stall u0 (
    .clk_i(clk), .rst_ni(rst_ni), .issue_valid_i(issue_valid_i),
    .issue_hint_i(issue_hint_i), .issue_imm_i(issue_imm_i),
    .issue_tag_i(issue_tag_i), .cmpl_valid_i(cmpl_valid_i),
    .cmpl_tag_i(cmpl_tag_i), .stall_o(stall_o)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: stall_o=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic vec(input int tag);
    @(negedge clk);
    issue_valid_i = 1'b1; issue_hint_i = 1'b0; issue_tag_i = 4'(tag);
    @(negedge clk);
    issue_valid_i = 1'b0;
  endtask

  task automatic hint(input int imm);
    @(negedge clk);
    issue_valid_i = 1'b1; issue_hint_i = 1'b1; issue_imm_i = 16'(imm);
    @(negedge clk);
    issue_valid_i = 1'b0; issue_hint_i = 1'b0;
  endtask

  task automatic cmpl(input int tag);
    @(negedge clk);
    cmpl_valid_i = 1'b1; cmpl_tag_i = 4'(tag);
    @(negedge clk);
    cmpl_valid_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    check(stall_o, 1'b0, "R1 reset");
    hint(1);
    check(stall_o, 1'b0, "R1 empty history after reset");

    // First field: every count, code and completion pattern.
    for (int c = 0; c <= 5; c++)
      for (int n = 0; n < 16; n++)
        for (int m = 0; m < 16; m++) begin
          logic exp;
          string rq;
          do_reset();
          for (int k = 0; k < c; k++) vec(k + 1);
          for (int j = 0; j < 4; j++)
            if (m[j] && j < c) cmpl(c - j);
          hint(n);
          exp = (n >= 1 && n <= 4 && n <= c && !m[n-1]);
          if (n == 0 || n > 4) rq = "R3 code out of range";
          else if (n > c)      rq = "R4 code beyond count";
          else if (exp)        rq = "R2 stall on pending target";
          else                 rq = "R5 target done";
          check(stall_o, exp, rq);
          if (exp) begin
            cmpl(c - n + 1);
            check(stall_o, 1'b0, "R2 release after completion");
          end
          vec(9);
          check(stall_o, 1'b0, "R7 hint consumed");
        end

    // Second field: skip and code, younger vectors in between.
    for (int s = 0; s < 4; s++)
      for (int n2 = 1; n2 <= 4; n2++) begin
        do_reset();
        for (int k = 1; k <= 4; k++) vec(k);
        hint((n2 << 7) | (s << 4));
        for (int k = 0; k < s; k++) begin
          check(stall_o, 1'b0, "R8 earlier vector not guarded");
          vec(5 + k);
        end
        check(stall_o, 1'b1, "R8 guarded vector stalls");
        cmpl(5 + s - n2);
        check(stall_o, 1'b0, "R8 release on resolved target");
        vec(12);
        check(stall_o, 1'b0, "R8 second field consumed");
      end

    // Both fields on the same instruction.
    do_reset();
    for (int k = 1; k <= 3; k++) vec(k);
    hint((3 << 7) | 1);
    check(stall_o, 1'b1, "R8 both fields stall");
    cmpl(3);
    check(stall_o, 1'b1, "R8 second field still pending");
    cmpl(1);
    check(stall_o, 1'b0, "R8 both resolved");

    // Foreign completion tag has no effect.
    do_reset();
    vec(1); vec(2);
    hint(2);
    cmpl(7);
    check(stall_o, 1'b1, "R10 foreign tag ignored");
    cmpl(1);
    check(stall_o, 1'b0, "R10 matching tag releases");

    // Hints do not count as vectors.
    do_reset();
    vec(1);
    hint(0); hint(0);
    hint(2);
    check(stall_o, 1'b0, "R9 hints not counted");

    // Held issue during stall.
    do_reset();
    vec(1);
    hint(1);
    @(negedge clk);
    issue_valid_i = 1'b1; issue_hint_i = 1'b0; issue_tag_i = 4'd7;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(stall_o, 1'b1, "R6 held issue not accepted");
    end
    cmpl_valid_i = 1'b1; cmpl_tag_i = 4'd1;
    @(negedge clk);
    cmpl_valid_i = 1'b0;
    check(stall_o, 1'b0, "R6 release while held");
    @(negedge clk);
    issue_valid_i = 1'b0;
    hint(3);
    check(stall_o, 1'b0, "R6 recorded once (count 2)");
    hint(2);
    check(stall_o, 1'b0, "R6 older entry done");
    hint(1);
    check(stall_o, 1'b1, "R6 held vector now newest");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule